// File: doc/BRIEF.md
# Host Start-of-Frame Timer

This block paces the host side of a serial bus into frames. A down-counter measured in PHY clock cycles holds the time left in the current frame. When it runs out while the host is enabled, the block issues a one-cycle start-of-frame pulse. In the same step it reloads the counter from a programmable interval and moves a 14-bit frame number forward.

A sticky interrupt status bit records that a start-of-frame occurred. Software clears it with a write-one strobe. Software can also request a frame-number restart, and the next start-of-frame then carries number zero. Building and sending the token on the wire is done downstream; this block only supplies the timing, the number and the status.

Top module: `sof_frame_timer`

## Requirements
- R1: While `host_en` is 1 and `time_left_o` is nonzero, `time_left_o` decreases by exactly one on each clock.
- R2: When `host_en` is 1 and `time_left_o` is 0, on the next clock `time_left_o` takes the value of `interval_i`, and `sof_pulse_o` is 1 for exactly that one cycle. A steady interval N therefore gives one pulse every N+1 cycles.
- R3: Each start-of-frame raises `frame_num_o` by one, unless R4 or R6 applies.
- R4: A start-of-frame taken while `frame_num_o` equals 14'h3FFF sets `frame_num_o` to 0.
- R5: `sof_irq_o` becomes 1 on the cycle of each start-of-frame pulse. It stays 1 until a cycle in which `irq_clr_i` is 1 and no new start-of-frame occurs. A start-of-frame in the same cycle as the clear takes priority, and the bit stays set.
- R6: A one-cycle pulse on `frnum_rst_req_i` is remembered. The next start-of-frame, including one in the same cycle as the pulse, sets `frame_num_o` to 0. Later start-of-frames count up normally from there.
- R7: A change of `interval_i` has no effect on a countdown already in progress. It is used only at the next reload.
- R8: While `host_en` is 0, `time_left_o` and `frame_num_o` hold their values and `sof_pulse_o` stays 0.
- R9: After reset, `time_left_o`, `frame_num_o`, `sof_pulse_o` and `sof_irq_o` are all 0. The first enabled cycle therefore starts a frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_phy | input | 1 | PHY clock that the countdown runs on |
| rst_n | input | 1 | Active-low reset |
| host_en | input | 1 | Enables counting and start-of-frame generation |
| interval_i | input | 16 | Frame length in PHY clocks, minus one |
| frnum_rst_req_i | input | 1 | Pulse: the next frame gets number 0 |
| irq_clr_i | input | 1 | Write-one strobe that clears the status bit |
| sof_pulse_o | output | 1 | One-cycle start-of-frame indication |
| frame_num_o | output | 14 | Number of the current frame |
| time_left_o | output | 16 | PHY clocks remaining in the current frame |
| sof_irq_o | output | 1 | Sticky start-of-frame interrupt status |

## Verification
The assertions assume that every input is a clean synchronous level sampled at the rising edge. They also assume that `frnum_rst_req_i` and `irq_clr_i` are single strobes that may coincide with a start-of-frame. Otherwise no ordering between them is assumed.

The random phase draws short intervals (0 to 20) so that reloads, coincident clears and interval changes in the middle of a countdown happen often. `host_en` drops in about one cycle in ten. The 14-bit wrap is reached by a directed run with interval 0, where every cycle is a frame.

// File: rtl/sof_timer_pkg.sv
package sof_timer_pkg;
    localparam int TIME_W  = 16;
    localparam int FRAME_W = 14;

    typedef struct packed {
        logic [TIME_W-1:0] time_left;
        logic              sof;
    } cnt_state_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               restart_pend;
    } frm_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/sof_countdown.sv
module sof_countdown
    import sof_timer_pkg::*;
#(
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] reload_val,
    output logic          sof_evt,
    output logic          sof_pulse,
    output logic [TW-1:0] time_left
);
    typedef struct packed {
        logic [TW-1:0] time_left;
        logic          sof;
    } st_t;

    st_t st_d, st_q;

    // A frame boundary occurs when the enabled counter sits at zero.
    assign sof_evt = enable && (st_q.time_left == '0);

    always_comb begin
        st_d     = st_q;
        st_d.sof = sof_evt;
        if (sof_evt) begin
            st_d.time_left = reload_val;
        end else if (enable) begin
            st_d.time_left = st_q.time_left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sof_pulse = st_q.sof;
    assign time_left = st_q.time_left;

    assert_decrement_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && time_left != '0) |=> (time_left == $past(time_left) - 1'b1));

    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && time_left == '0) |=> (sof_pulse && time_left == $past(reload_val)));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_pulse && time_left != '0) |=> !sof_pulse);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(time_left) && !sof_pulse));
endmodule

// File: rtl/sof_frame_counter.sv
module sof_frame_counter
    import sof_timer_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof_evt,
    input  logic          restart_req,
    output logic [FW-1:0] frame_num
);
    localparam logic [FW-1:0] FRAME_MAX = {FW{1'b1}};

    typedef struct packed {
        logic [FW-1:0] frame;
        logic          pend;
    } st_t;

    st_t  st_d, st_q;
    logic restart_now;

    assign restart_now = st_q.pend | restart_req;

    always_comb begin
        st_d      = st_q;
        st_d.pend = restart_now & ~sof_evt;
        if (sof_evt) begin
            if (restart_now || st_q.frame == FRAME_MAX) begin
                st_d.frame = '0;
            end else begin
                st_d.frame = st_q.frame + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_num = st_q.frame;

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_evt && frame_num == FRAME_MAX) |=> (frame_num == '0));

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_evt && restart_req) |=> (frame_num == '0));

    assert_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_evt |=> $stable(frame_num));
endmodule

// File: rtl/sof_irq_status.sv
module sof_irq_status
    import sof_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = set_i | (st_q.irq & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o);
endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer
    import sof_timer_pkg::*;
#(
    parameter int TW = TIME_W,
    parameter int FW = FRAME_W
) (
    input  logic          clk_phy,
    input  logic          rst_n,
    input  logic          host_en,
    input  logic [TW-1:0] interval_i,
    input  logic          frnum_rst_req_i,
    input  logic          irq_clr_i,
    output logic          sof_pulse_o,
    output logic [FW-1:0] frame_num_o,
    output logic [TW-1:0] time_left_o,
    output logic          sof_irq_o
);
    logic sof_evt;

    sof_countdown #(.TW(TW)) u_cnt (
        .clk        (clk_phy),
        .rst_n      (rst_n),
        .enable     (host_en),
        .reload_val (interval_i),
        .sof_evt    (sof_evt),
        .sof_pulse  (sof_pulse_o),
        .time_left  (time_left_o)
    );

    sof_frame_counter #(.FW(FW)) u_frm (
        .clk         (clk_phy),
        .rst_n       (rst_n),
        .sof_evt     (sof_evt),
        .restart_req (frnum_rst_req_i),
        .frame_num   (frame_num_o)
    );

    sof_irq_status u_irq (
        .clk   (clk_phy),
        .rst_n (rst_n),
        .set_i (sof_evt),
        .clr_i (irq_clr_i),
        .irq_o (sof_irq_o)
    );

    assert_pulse_sets_irq_R5: assert property (@(posedge clk_phy) disable iff (!rst_n)
        sof_pulse_o |-> sof_irq_o);

    assert_pulse_moves_frame_R3: assert property (@(posedge clk_phy) disable iff (!rst_n)
        (host_en && time_left_o != '0) |=> $stable(frame_num_o));
endmodule

// File: tb/sof_frame_timer_tb.sv
module sof_frame_timer_tb_top;
    localparam int TW = 16;
    localparam int FW = 14;
    localparam int FMAX = (1 << FW) - 1;

    logic          clk_phy = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_en = 1'b0;
    logic [TW-1:0] interval_i = '0;
    logic          frnum_rst_req_i = 1'b0;
    logic          irq_clr_i = 1'b0;
    logic          sof_pulse_o;
    logic [FW-1:0] frame_num_o;
    logic [TW-1:0] time_left_o;
    logic          sof_irq_o;

    int checks = 0;
    int errors = 0;

    // reference state
    int unsigned m_tl, m_fn;
    bit m_pend, m_irq, m_sof;

    always #2.5 clk_phy = ~clk_phy;

    sof_frame_timer dut_i (
        .clk_phy         (clk_phy),
        .rst_n           (rst_n),
        .host_en         (host_en),
        .interval_i      (interval_i),
        .frnum_rst_req_i (frnum_rst_req_i),
        .irq_clr_i       (irq_clr_i),
        .sof_pulse_o     (sof_pulse_o),
        .frame_num_o     (frame_num_o),
        .time_left_o     (time_left_o),
        .sof_irq_o       (sof_irq_o)
    );

    function automatic int unsigned next_frame(int unsigned fn, bit restart);
        if (restart || fn == FMAX) return 0;
        return fn + 1;
    endfunction

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1/R2/R7/R8 time_left", time_left_o, m_tl);
        chk("R2/R8 sof_pulse", sof_pulse_o, m_sof);
        chk("R3/R4/R6 frame_num", frame_num_o, m_fn);
        chk("R5 sof_irq", sof_irq_o, m_irq);
    endtask

    // called just after a falling edge: drive, advance model, compare at next falling edge
    task automatic step(bit en, int unsigned iv, bit rreq, bit clr);
        bit e;
        host_en = en;
        interval_i = iv[TW-1:0];
        frnum_rst_req_i = rreq;
        irq_clr_i = clr;
        e = en && (m_tl == 0);
        m_sof = e;
        if (e) begin
            m_fn = next_frame(m_fn, m_pend || rreq);
            m_pend = 1'b0;
            m_tl = iv & 16'hFFFF;
        end else begin
            m_pend = m_pend || rreq;
            if (en) m_tl = m_tl - 1;
        end
        m_irq = e || (m_irq && !clr);
        @(posedge clk_phy);
        @(negedge clk_phy);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        host_en = 1'b0;
        frnum_rst_req_i = 1'b0;
        irq_clr_i = 1'b0;
        m_tl = 0; m_fn = 0; m_pend = 0; m_irq = 0; m_sof = 0;
        repeat (3) @(negedge clk_phy);
        // R9: reset values
        chk("R9 time_left", time_left_o, 0);
        chk("R9 frame_num", frame_num_o, 0);
        chk("R9 sof_pulse", sof_pulse_o, 0);
        chk("R9 sof_irq", sof_irq_o, 0);
        rst_n = 1'b1;
        @(negedge clk_phy);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R9/R2: first enabled cycle starts a frame, then period N+1 with N=4
        for (int i = 0; i < 12; i++) step(1, 4, 0, 0);

        // R8: disabled holds everything
        for (int i = 0; i < 6; i++) step(0, 9, 0, 0);

        // R7: interval changes mid-count do not disturb the countdown
        step(1, 10, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 3 + i, 0, 0);
        for (int i = 0; i < 12; i++) step(1, 2, 0, 0);

        // R5: clear alone, then clear coincident with a frame start
        for (int i = 0; i < 6; i++) step(1, 5, 0, (m_tl == 2));
        while (m_tl != 0) step(1, 5, 0, 0);
        step(1, 5, 0, 1);

        // R6: restart request mid-frame and coincident with a frame start
        step(1, 5, 1, 0);
        while (m_tl != 0) step(1, 5, 0, 0);
        step(1, 5, 0, 0);
        for (int i = 0; i < 8; i++) step(1, 5, 0, 0);
        while (m_tl != 0) step(1, 5, 0, 0);
        step(1, 5, 1, 0);

        // R4: wrap of the 14-bit frame number with interval 0
        do_reset();
        for (int i = 0; i < FMAX + 20; i++) step(1, 0, 0, (i % 97) == 0);

        // random mix
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom();
            step((r % 10) != 0, (r >> 4) % 21, ((r >> 12) % 40) == 0, ((r >> 18) % 5) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule